// File: doc/BRIEF.md
# Debug Breakpoint Trigger Unit

This block watches a processor's instruction fetch addresses and its data-bus transfers, and turns selected matches into a debug interrupt request that carries a vector offset. A program-counter match is reported at once, in the same cycle as the matching fetch, so the fetch stage can hold the instruction before it runs. A data-bus match is latched into a pending request that stays up until the interrupt controller acknowledges it, so it is serviced like any other interrupt.

Four program-counter breakpoint slots, each with its own valid flag, feed one combined program-counter event. One data breakpoint value with a per-bit don't-care mask feeds the bus event. A trigger-control register holds two condition groups. With one group enabled, its selected events raise a request directly. With both groups enabled, a first-level event arms the unit and a later second-level event raises the request. The kind of event that completes the sequence decides which vector is reported.

All compares are aligned 32-bit compares. Only a longword transfer on a 4-byte boundary can match the data breakpoint.

Top module: `dbg_trig_unit`

## Requirements
- R1: After reset, `pc_hit`, `irq_req` and `irq_vec_off` are 0, and the trigger-control register is 0. Matching traffic therefore raises nothing until that register is written.
- R2: Program-counter slots 0 to 3 are written at `reg_addr` 0 to 3. Bits 31:1 of a slot are compared with `fetch_pc`. The four slot results are ORed into one program-counter event.
- R3: A slot whose bit 0 (valid) is 0 never matches, whatever address it holds.
- R4: The data value is written at `reg_addr` 4 and the mask at `reg_addr` 5. A bus transfer matches when every data bit whose mask bit is 0 equals the stored value. Data bits whose mask bit is 1 are ignored.
- R5: The data breakpoint matches only when `bus_size` is 2'b10 (longword) and `bus_addr_lo` is 2'b00. Byte transfers (2'b00) and word transfers (2'b01) never match, and neither do misaligned transfers.
- R6: A program-counter request is precise. `pc_hit` is high for exactly the cycle in which the matching `fetch_valid` is presented, with `irq_vec_off` = 0x34. It sets no pending state.
- R7: A bus-event request raises `irq_req` in the cycle after the matching transfer, with `irq_vec_off` = 0x30. The request stays high until `irq_ack` is sampled high. A new bus request in the same cycle as `irq_ack` wins, and the request stays set.
- R8: The trigger-control register is written at `reg_addr` 6. In the first-level group, bit 2 is the enable, bit 3 selects the program-counter event and bit 4 selects the bus event. In the second-level group, bits 18, 19 and 20 have the same meanings. With both enables clear, no request is produced. With exactly one enable set, that group works as a one-level trigger.
- R9: With both enables set, a first-level event only arms the unit. A second-level event seen while armed raises the request and disarms the unit. The second-level event's kind picks the vector: 0x34 with a precise `pc_hit`, or 0x30 with a pending `irq_req`.
- R10: Any write to the trigger-control register clears the armed state.
- R11: If a program-counter event and a bus event both fire in one cycle, `pc_hit` is raised in that cycle with `irq_vec_off` = 0x34, and `irq_req` follows in the next cycle with `irq_vec_off` = 0x30.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select (0-3 PC slots, 4 data value, 5 data mask, 6 trigger control) |
| reg_wdata | input | 32 | Register write data |
| fetch_valid | input | 1 | A fetch address is presented this cycle |
| fetch_pc | input | 31 | Fetch address bits 31:1 |
| bus_valid | input | 1 | A data-bus transfer is presented this cycle |
| bus_addr_lo | input | 2 | Low two bits of the transfer address |
| bus_size | input | 2 | Transfer size (00 byte, 01 word, 10 longword) |
| bus_data | input | 32 | Transfer data |
| irq_ack | input | 1 | Acknowledge that clears the pending bus-event request |
| pc_hit | output | 1 | Precise program-counter request, aligned to the fetch |
| irq_req | output | 1 | Pending bus-event request |
| irq_vec_off | output | 8 | Vector offset: 0x34 for a PC request, 0x30 for a bus request, else 0 |

## Verification
A program-counter match and a bus match can be detected in the same cycle, and each then takes a different path to the output. To provoke this, the bench presents a matching fetch and a matching longword transfer together while both event kinds are selected in one group. It checks that `pc_hit` and vector 0x34 appear combinationally in that cycle, and that `irq_req` with 0x30 appears one edge later. A second collision, a new bus match arriving with `irq_ack`, is judged by checking that the request remains set afterwards.

// File: rtl/dbg_trig_pkg.sv
// Shared constants and types for the debug trigger unit.
// Assumes a 3-bit register select and the fixed register map below.
package dbg_trig_pkg;

    localparam int REG_AW     = 3;
    localparam int MAX_PCBP   = 4;
    localparam int L1_LSB     = 2;
    localparam int L2_LSB     = 18;

    localparam logic [REG_AW-1:0] RA_DVAL  = 3'd4;
    localparam logic [REG_AW-1:0] RA_DMASK = 3'd5;
    localparam logic [REG_AW-1:0] RA_TCTL  = 3'd6;

    localparam logic [1:0] SZ_LONG = 2'b10;

    localparam logic [7:0] VEC_PC  = 8'h34;
    localparam logic [7:0] VEC_BUS = 8'h30;

    // Per-level condition group: enable plus event selects.
    typedef struct packed {
        logic en;
        logic use_pc;
        logic use_data;
    } lvl_cfg_t;

    // Pull one condition group out of the trigger-control word.
    function automatic lvl_cfg_t take_lvl(input logic [31:0] w, input int lsb);
        lvl_cfg_t c;
        c.en       = w[lsb];
        c.use_pc   = w[lsb+1];
        c.use_data = w[lsb+2];
        return c;
    endfunction

endpackage

// File: rtl/dbg_trig_regs.sv
// Register file of the trigger unit: PC slots, data value, mask and
// the two decoded trigger condition groups. Assumes single-cycle writes;
// a write takes effect on the next cycle. Flags every trigger-control write.
module dbg_trig_regs
    import dbg_trig_pkg::*;
#(
    parameter int AW       = 32,
    parameter int DW       = 32,
    parameter int NUM_PCBP = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          reg_we,
    input  logic [REG_AW-1:0]             reg_addr,
    input  logic [31:0]                   reg_wdata,
    output logic [NUM_PCBP-1:0][AW-1:0]   pcbp,
    output logic [DW-1:0]                 dval,
    output logic [DW-1:0]                 dmask,
    output lvl_cfg_t                      lvl1,
    output lvl_cfg_t                      lvl2,
    output logic                          tctl_we
);

    assign tctl_we = reg_we && (reg_addr == RA_TCTL);

    // PC breakpoint slots, one register per generated slot.
    for (genvar i = 0; i < NUM_PCBP; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                pcbp[i] <= '0;
            else if (reg_we && reg_addr == REG_AW'(i))
                pcbp[i] <= reg_wdata[AW-1:0];
        end
    end

    // Data breakpoint value and don't-care mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dval  <= '0;
            dmask <= '0;
        end else if (reg_we) begin
            if (reg_addr == RA_DVAL)  dval  <= reg_wdata[DW-1:0];
            if (reg_addr == RA_DMASK) dmask <= reg_wdata[DW-1:0];
        end
    end

    // Trigger-control condition groups, decoded at write time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl1 <= '0;
            lvl2 <= '0;
        end else if (tctl_we) begin
            lvl1 <= take_lvl(reg_wdata, L1_LSB);
            lvl2 <= take_lvl(reg_wdata, L2_LSB);
        end
    end

endmodule

// File: rtl/dbg_pc_match.sv
// Program-counter comparators: one per slot, results ORed.
// Assumes halfword-aligned fetch addresses (bit 0 not presented) and
// slot bit 0 as the valid flag.
module dbg_pc_match #(
    parameter int AW       = 32,
    parameter int NUM_PCBP = 4
) (
    input  logic                        fetch_valid,
    input  logic [AW-1:1]               fetch_pc,
    input  logic [NUM_PCBP-1:0][AW-1:0] pcbp,
    output logic                        pc_ev
);

    logic [NUM_PCBP-1:0] slot_hit;

    for (genvar i = 0; i < NUM_PCBP; i++) begin : g_cmp
        // Slot compares only when its valid flag is set.
        assign slot_hit[i] = pcbp[i][0] && (pcbp[i][AW-1:1] == fetch_pc);
    end

    assign pc_ev = fetch_valid && (|slot_hit);

endmodule

// File: rtl/dbg_data_match.sv
// Data breakpoint comparator with per-bit don't-care mask.
// Assumes only aligned longword transfers are candidates.
module dbg_data_match
    import dbg_trig_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          bus_valid,
    input  logic [1:0]    bus_addr_lo,
    input  logic [1:0]    bus_size,
    input  logic [DW-1:0] bus_data,
    input  logic [DW-1:0] dval,
    input  logic [DW-1:0] dmask,
    output logic          data_ev
);

    logic aligned_long;
    logic bits_eq;

    // Candidate transfer: longword on a 4-byte boundary.
    assign aligned_long = (bus_size == SZ_LONG) && (bus_addr_lo == 2'b00);
    // Unmasked bits must agree with the stored value.
    assign bits_eq      = ((bus_data ^ dval) & ~dmask) == '0;
    assign data_ev      = bus_valid && aligned_long && bits_eq;

endmodule

// File: rtl/dbg_trig_seq.sv
// Trigger sequencer: applies the one- or two-level condition groups to the
// raw events, keeps the armed flag and the pending bus-event request.
// Assumes events are single-cycle qualified strobes.
module dbg_trig_seq
    import dbg_trig_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  lvl_cfg_t lvl1,
    input  lvl_cfg_t lvl2,
    input  logic     tctl_we,
    input  logic     pc_ev,
    input  logic     data_ev,
    input  logic     irq_ack,
    output logic     pc_fire,
    output logic     pend
);

    logic two_lvl;
    logic armed;
    logic l1_any, l2_pc, l2_dt, l1_pc, l1_dt;
    logic fire_dt;
    logic arm_set, arm_clr;

    assign two_lvl = lvl1.en && lvl2.en;
    assign l1_pc   = lvl1.use_pc   && pc_ev;
    assign l1_dt   = lvl1.use_data && data_ev;
    assign l2_pc   = lvl2.use_pc   && pc_ev;
    assign l2_dt   = lvl2.use_data && data_ev;
    assign l1_any  = l1_pc || l1_dt;

    // Choose which events fire according to the active trigger mode.
    always_comb begin
        pc_fire = 1'b0;
        fire_dt = 1'b0;
        arm_set = 1'b0;
        arm_clr = 1'b0;
        if (two_lvl) begin
            if (armed) begin
                pc_fire = l2_pc;
                fire_dt = l2_dt;
                arm_clr = l2_pc || l2_dt;
            end else begin
                arm_set = l1_any;
            end
        end else if (lvl1.en) begin
            pc_fire = l1_pc;
            fire_dt = l1_dt;
        end else if (lvl2.en) begin
            pc_fire = l2_pc;
            fire_dt = l2_dt;
        end
    end

    // Armed flag for the two-level sequence; cleared by control writes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed <= 1'b0;
        else if (tctl_we || !two_lvl)
            armed <= 1'b0;
        else if (arm_set)
            armed <= 1'b1;
        else if (arm_clr)
            armed <= 1'b0;
    end

    // Pending imprecise request; a new event outranks the acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend <= 1'b0;
        else if (fire_dt)
            pend <= 1'b1;
        else if (irq_ack)
            pend <= 1'b0;
    end

    // R10: a control write leaves the unit disarmed.
    a_r10_write_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        tctl_we |=> !armed);

    // R9: the armed flag only rises in two-level mode.
    a_r9_arm_needs_two_lvl: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> $past(two_lvl));

    // R8: with both groups disabled nothing new becomes pending.
    a_r8_off_stays_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!lvl1.en && !lvl2.en && !pend) |=> !pend);

    // R7: a pending request holds until acknowledged.
    a_r7_pend_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !irq_ack) |=> pend);

endmodule

// File: rtl/dbg_trig_unit.sv
// Debug breakpoint trigger unit top: register file, PC and data
// comparators, trigger sequencer and vector selection.
// Assumes aligned 32-bit data compares and a synchronous active-low reset.
module dbg_trig_unit
    import dbg_trig_pkg::*;
#(
    parameter int AW       = 32,
    parameter int DW       = 32,
    parameter int NUM_PCBP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic              fetch_valid,
    input  logic [AW-1:1]     fetch_pc,
    input  logic              bus_valid,
    input  logic [1:0]        bus_addr_lo,
    input  logic [1:0]        bus_size,
    input  logic [DW-1:0]     bus_data,
    input  logic              irq_ack,
    output logic              pc_hit,
    output logic              irq_req,
    output logic [7:0]        irq_vec_off
);

    logic [NUM_PCBP-1:0][AW-1:0] pcbp;
    logic [DW-1:0]               dval, dmask;
    lvl_cfg_t                    lvl1, lvl2;
    logic                        tctl_we;
    logic                        pc_ev, data_ev;

    dbg_trig_regs #(.AW(AW), .DW(DW), .NUM_PCBP(NUM_PCBP)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .pcbp(pcbp), .dval(dval), .dmask(dmask),
        .lvl1(lvl1), .lvl2(lvl2), .tctl_we(tctl_we)
    );

    dbg_pc_match #(.AW(AW), .NUM_PCBP(NUM_PCBP)) u_pc (
        .fetch_valid(fetch_valid), .fetch_pc(fetch_pc), .pcbp(pcbp),
        .pc_ev(pc_ev)
    );

    dbg_data_match #(.DW(DW)) u_data (
        .bus_valid(bus_valid), .bus_addr_lo(bus_addr_lo), .bus_size(bus_size),
        .bus_data(bus_data), .dval(dval), .dmask(dmask), .data_ev(data_ev)
    );

    dbg_trig_seq u_seq (
        .clk(clk), .rst_n(rst_n), .lvl1(lvl1), .lvl2(lvl2), .tctl_we(tctl_we),
        .pc_ev(pc_ev), .data_ev(data_ev), .irq_ack(irq_ack),
        .pc_fire(pc_hit), .pend(irq_req)
    );

    // Vector offset: the precise request outranks the pending one.
    always_comb begin
        if (pc_hit)
            irq_vec_off = VEC_PC;
        else if (irq_req)
            irq_vec_off = VEC_BUS;
        else
            irq_vec_off = '0;
    end

    // R6: a precise hit only exists alongside a presented fetch.
    a_r6_hit_with_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        pc_hit |-> fetch_valid);

    // R6, R11: a precise hit always carries the PC vector.
    a_r11_pc_vector_wins: assert property (@(posedge clk) disable iff (!rst_n)
        pc_hit |-> (irq_vec_off == VEC_PC));

    // R7: a pending request only rises after a bus transfer.
    a_r7_rise_after_bus: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> $past(bus_valid));

endmodule

// File: tb/tb_dbg_trig_unit.sv
// Directed bench for the debug trigger unit, one task per scenario.
module tb_dbg_trig_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        fetch_valid = 1'b0;
    logic [31:1] fetch_pc = '0;
    logic        bus_valid = 1'b0;
    logic [1:0]  bus_addr_lo = '0;
    logic [1:0]  bus_size = '0;
    logic [31:0] bus_data = '0;
    logic        irq_ack = 1'b0;
    logic        pc_hit, irq_req;
    logic [7:0]  irq_vec_off;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dbg_trig_unit dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
        .bus_valid(bus_valid), .bus_addr_lo(bus_addr_lo), .bus_size(bus_size),
        .bus_data(bus_data), .irq_ack(irq_ack), .pc_hit(pc_hit),
        .irq_req(irq_req), .irq_vec_off(irq_vec_off)
    );

    localparam logic [31:0] TC_L1_PC  = 32'h0000_000C;
    localparam logic [31:0] TC_L1_DT  = 32'h0000_0014;
    localparam logic [31:0] TC_L1_ALL = 32'h0000_001C;
    localparam logic [31:0] TC_L2_PC  = 32'h000C_0000;
    localparam logic [31:0] TC_L2_DT  = 32'h0014_0000;
    localparam logic [31:0] DV        = 32'hDEAD_BEEF;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        #1;
    endtask

    // One cycle of stimulus; samples the precise path inside the cycle
    // and the pending path after the following edge.
    task automatic step(input logic fv, input logic [31:0] pc, input logic bv,
                        input logic [31:0] d, input logic [1:0] sz,
                        input logic [1:0] lo, input logic ack,
                        output logic hit, output logic [7:0] vh,
                        output logic req, output logic [7:0] vr);
        fetch_valid = fv; fetch_pc = pc[31:1];
        bus_valid = bv; bus_data = d; bus_size = sz; bus_addr_lo = lo;
        irq_ack = ack;
        #1;
        hit = pc_hit; vh = irq_vec_off;
        @(negedge clk);
        fetch_valid = 1'b0; bus_valid = 1'b0; irq_ack = 1'b0;
        #1;
        req = irq_req; vr = irq_vec_off;
    endtask

    logic h, q;
    logic [7:0] vh, vq;

    task automatic t_reset;
        check("R1 pc_hit", {31'b0, pc_hit}, 32'd0);
        check("R1 irq_req", {31'b0, irq_req}, 32'd0);
        check("R1 vec", {24'b0, irq_vec_off}, 32'd0);
        wr(3'd0, 32'h3000_0001);
        wr(3'd4, DV);
        step(1, 32'h3000_0000, 1, DV, 2'b10, 2'b00, 0, h, vh, q, vq);
        check("R1 no hit with control at reset", {31'b0, h}, 32'd0);
        check("R1 no pending with control at reset", {31'b0, q}, 32'd0);
    endtask

    task automatic t_pc_basic;
        wr(3'd6, TC_L1_PC);
        wr(3'd2, 32'h1000_0041);
        step(1, 32'h1000_0040, 0, 0, 0, 0, 0, h, vh, q, vq);
        check("R2 slot2 hit", {31'b0, h}, 32'd1);
        check("R6 pc vector", {24'b0, vh}, 32'h34);
        check("R6 no pending from pc", {31'b0, q}, 32'd0);
        check("R6 pulse ends", {31'b0, pc_hit}, 32'd0);
        step(1, 32'h1000_0042, 0, 0, 0, 0, 0, h, vh, q, vq);
        check("R2 other address", {31'b0, h}, 32'd0);
        step(0, 32'h1000_0040, 0, 0, 0, 0, 0, h, vh, q, vq);
        check("R6 no fetch no hit", {31'b0, h}, 32'd0);
    endtask

    task automatic t_valid;
        wr(3'd1, 32'h2000_0000);
        step(1, 32'h2000_0000, 0, 0, 0, 0, 0, h, vh, q, vq);
        check("R3 invalid slot", {31'b0, h}, 32'd0);
        wr(3'd3, 32'h4000_0011);
        step(1, 32'h4000_0010, 0, 0, 0, 0, 0, h, vh, q, vq);
        check("R2 slot3 ORed", {31'b0, h}, 32'd1);
    endtask

    task automatic t_data;
        wr(3'd6, TC_L1_DT);
        wr(3'd5, 32'h0000_00FF);
        step(0, 0, 1, 32'hDEAD_BE00, 2'b10, 2'b00, 0, h, vh, q, vq);
        check("R4 masked match", {31'b0, q}, 32'd1);
        check("R7 bus vector", {24'b0, vq}, 32'h30);
        step(0, 0, 0, 0, 0, 0, 0, h, vh, q, vq);
        check("R7 holds", {31'b0, q}, 32'd1);
        step(0, 0, 1, DV, 2'b10, 2'b00, 1, h, vh, q, vq);
        check("R7 set beats ack", {31'b0, q}, 32'd1);
        step(0, 0, 0, 0, 0, 0, 1, h, vh, q, vq);
        check("R7 ack clears", {31'b0, q}, 32'd0);
        check("R7 vector idle", {24'b0, vq}, 32'd0);
        step(0, 0, 1, 32'hDEAC_BEEF, 2'b10, 2'b00, 0, h, vh, q, vq);
        check("R4 unmasked mismatch", {31'b0, q}, 32'd0);
        step(0, 0, 1, DV, 2'b01, 2'b00, 0, h, vh, q, vq);
        check("R5 word size", {31'b0, q}, 32'd0);
        step(0, 0, 1, DV, 2'b00, 2'b00, 0, h, vh, q, vq);
        check("R5 byte size", {31'b0, q}, 32'd0);
        step(0, 0, 1, DV, 2'b10, 2'b01, 0, h, vh, q, vq);
        check("R5 misaligned", {31'b0, q}, 32'd0);
    endtask

    task automatic t_two_level_bus_last;
        wr(3'd6, TC_L1_PC | TC_L2_DT);
        step(0, 0, 1, DV, 2'b10, 2'b00, 0, h, vh, q, vq);
        check("R9 second level unarmed", {31'b0, q}, 32'd0);
        step(1, 32'h3000_0000, 0, 0, 0, 0, 0, h, vh, q, vq);
        check("R9 first level only arms", {31'b0, h}, 32'd0);
        step(0, 0, 1, DV, 2'b10, 2'b00, 0, h, vh, q, vq);
        check("R9 bus completes", {31'b0, q}, 32'd1);
        check("R9 bus vector", {24'b0, vq}, 32'h30);
        step(0, 0, 0, 0, 0, 0, 1, h, vh, q, vq);
        step(0, 0, 1, DV, 2'b10, 2'b00, 0, h, vh, q, vq);
        check("R9 disarmed after fire", {31'b0, q}, 32'd0);
    endtask

    task automatic t_two_level_pc_last;
        wr(3'd6, TC_L1_DT | TC_L2_PC);
        step(0, 0, 1, DV, 2'b10, 2'b00, 0, h, vh, q, vq);
        check("R9 arm not pending", {31'b0, q}, 32'd0);
        step(1, 32'h3000_0000, 0, 0, 0, 0, 0, h, vh, q, vq);
        check("R9 pc completes", {31'b0, h}, 32'd1);
        check("R9 pc vector", {24'b0, vh}, 32'h34);
        check("R9 no pending", {31'b0, q}, 32'd0);
    endtask

    task automatic t_rewrite_disarms;
        step(0, 0, 1, DV, 2'b10, 2'b00, 0, h, vh, q, vq);
        wr(3'd6, TC_L1_DT | TC_L2_PC);
        step(1, 32'h3000_0000, 0, 0, 0, 0, 0, h, vh, q, vq);
        check("R10 write disarms", {31'b0, h}, 32'd0);
    endtask

    task automatic t_concurrent;
        wr(3'd6, TC_L1_ALL);
        step(1, 32'h3000_0000, 1, DV, 2'b10, 2'b00, 0, h, vh, q, vq);
        check("R11 pc hit same cycle", {31'b0, h}, 32'd1);
        check("R11 pc vector first", {24'b0, vh}, 32'h34);
        check("R11 pending next", {31'b0, q}, 32'd1);
        check("R11 bus vector next", {24'b0, vq}, 32'h30);
        step(0, 0, 0, 0, 0, 0, 1, h, vh, q, vq);
    endtask

    task automatic t_modes;
        wr(3'd6, TC_L2_PC);
        step(1, 32'h3000_0000, 1, DV, 2'b10, 2'b00, 0, h, vh, q, vq);
        check("R8 second group alone hit", {31'b0, h}, 32'd1);
        check("R8 bus not selected", {31'b0, q}, 32'd0);
        wr(3'd6, 32'h0000_0000);
        step(1, 32'h3000_0000, 1, DV, 2'b10, 2'b00, 0, h, vh, q, vq);
        check("R8 disabled no hit", {31'b0, h}, 32'd0);
        check("R8 disabled no pending", {31'b0, q}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_pc_basic();
        t_valid();
        t_data();
        t_two_level_bus_last();
        t_two_level_pc_last();
        t_rewrite_disarms();
        t_concurrent();
        t_modes();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule